// File: doc/BRIEF.md
# PLL Relock Wait Controller

This block holds the run-mode clock settings of a chip and decides when the PLL output may drive the system clock. A base settings register carries a crystal-select code, a PLL power-down bit, a bypass bit and an output divisor. An extension register can replace the power-down, bypass and divisor fields of the base register with its own values, including a wider divisor, while its enable bit is set. The crystal code is also turned into a read-only PLL configuration word through a small table.

Some setting changes make the PLL unstable until it locks again. These are a crystal code that really differs from the stored one, or the effective power-down moving from 1 to 0. Either one reloads a down counter that runs on the main-oscillator clock. Until that counter reaches zero, the lock-ready flag is low and the clock select stays on the oscillator path. The whole block runs on the main-oscillator clock, and register writes come in on that same clock.

Top module: `clkctl_relock_top`

## Requirements
- R1: After reset: pll_pd=1, pll_bypass=1, lock_ready=0, use_pll=0, sys_div=0, and pll_cfg holds the table entry for the reset crystal code (code 2, value 0x1C4).
- R2: A write with wr_ext=0 loads the base register: xtal in bits [3:0], power-down in bit 4, bypass in bit 5, divisor in bits [9:6]. A write with wr_ext=1 loads the extension register: power-down in bit 0, bypass in bit 1, divisor in bits [8:2], enable in bit 9. While the enable bit is 1, pll_pd, pll_bypass and sys_div follow the extension fields. Otherwise they follow the base fields, with the divisor zero-extended.
- R3: A base write whose crystal code differs from the stored code drives lock_ready to 0 after that clock edge. lock_ready stays 0 for exactly RELOCK_CNT cycles, counting the write edge's cycle, and is set again only when power-down is 0.
- R4: A base write that repeats the stored crystal code, with power-down unchanged at 0, leaves lock_ready at 1.
- R5: A 1-to-0 change of the effective power-down starts the same RELOCK_CNT-cycle wait. This includes a change caused by toggling the extension enable.
- R6: A trigger that arrives while a wait is in progress reloads the full RELOCK_CNT count.
- R7: lock_ready is 1 only while the effective power-down is 0. It drops on the cycle after power-down is entered.
- R8: use_pll is 1 exactly when lock_ready is 1 and the effective bypass is 0. Otherwise the clock select stays on the oscillator path.
- R9: pll_cfg changes only when the crystal code changes, and then takes the table entry for the new code: 0→0x0A3, 1→0x112, 2→0x1C4, 3→0x245, 4→0x2D6, 5→0x367, 6→0x3F8, 7→0x489, and any code 8–15→0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main-oscillator clock; also clocks the relock counter |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ext | input | 1 | 0 selects the base register, 1 selects the extension register |
| wr_data | input | WR_W (10) | Write data |
| pll_pd | output | 1 | Effective PLL power-down |
| pll_bypass | output | 1 | Effective bypass request |
| sys_div | output | EXT_DIV_W (7) | Effective output divisor |
| pll_cfg | output | CFG_W (12) | Translated PLL configuration (read-only) |
| lock_ready | output | 1 | PLL locked and usable |
| use_pll | output | 1 | 1 selects the PLL path for the system clock |

## Verification
The bench measures the exact length of the low window on lock_ready after a crystal change and after leaving power-down. A counter that is off by one, or that never reloads, shows up as a wrong cycle count. A second crystal change in the middle of a wait has to restart the count from the full value; a design that only loads an idle counter would report ready too early. A repeated write of the same crystal code must not disturb a locked PLL, so a design that triggers on every write would drop use_pll. The extension enable is toggled in both directions: a design with the wrong priority would output base divisor and power-down values, and one that missed the power-down edge caused by enable would report lock at once. Unsupported crystal codes must give the default table entry.

// File: rtl/clkctl_pkg.sv
// Package: shared widths and the crystal-to-PLL translation table.
// Assumes a 4-bit crystal code and a 12-bit configuration word.
package clkctl_pkg;

    localparam int XTAL_W = 4;
    localparam int CFG_W  = 12;

    // Map a crystal code to its PLL configuration word; unsupported codes give 0.
    function automatic logic [CFG_W-1:0] xlate_cfg(input logic [XTAL_W-1:0] code);
        logic [CFG_W-1:0] val;
        case (code)
            4'd0:    val = 12'h0A3;
            4'd1:    val = 12'h112;
            4'd2:    val = 12'h1C4;
            4'd3:    val = 12'h245;
            4'd4:    val = 12'h2D6;
            4'd5:    val = 12'h367;
            4'd6:    val = 12'h3F8;
            4'd7:    val = 12'h489;
            default: val = 12'h000;
        endcase
        return val;
    endfunction

endpackage

// File: rtl/clkctl_regs.sv
// Module: base and extension settings registers with field priority.
// It also detects relock triggers, from the values about to be written.
// Assumes both write layouts fit in WR_W and EXT_DIV_W >= DIV_W.
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter int              DIV_W     = 4,
    parameter int              EXT_DIV_W = 7,
    parameter int              WR_W      = 10,
    parameter logic [XTAL_W-1:0] XTAL_RST = 4'd2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_ext,
    input  logic [WR_W-1:0]      wr_data,
    output logic [XTAL_W-1:0]    xtal_cur,
    output logic [XTAL_W-1:0]    xtal_nxt,
    output logic                 pd_eff,
    output logic                 byp_eff,
    output logic [EXT_DIV_W-1:0] div_eff,
    output logic                 xtal_chg,
    output logic                 pd_exit
);

    localparam int B_PD  = XTAL_W;
    localparam int B_BYP = XTAL_W + 1;
    localparam int B_DIV = XTAL_W + 2;
    localparam int E_PD  = 0;
    localparam int E_BYP = 1;
    localparam int E_DIV = 2;
    localparam int E_EN  = WR_W - 1;

    logic                 b_pd, b_byp, b_pd_n, b_byp_n;
    logic [DIV_W-1:0]     b_div, b_div_n;
    logic                 e_en, e_pd, e_byp, e_en_n, e_pd_n, e_byp_n;
    logic [EXT_DIV_W-1:0] e_div, e_div_n;
    logic                 pd_eff_n;
    logic                 base_wr, ext_wr;

    assign base_wr = wr_en && !wr_ext;
    assign ext_wr  = wr_en &&  wr_ext;

    // Next-state values of both registers for this cycle's write.
    always_comb begin
        xtal_nxt = base_wr ? wr_data[XTAL_W-1:0]      : xtal_cur;
        b_pd_n   = base_wr ? wr_data[B_PD]            : b_pd;
        b_byp_n  = base_wr ? wr_data[B_BYP]           : b_byp;
        b_div_n  = base_wr ? wr_data[B_DIV +: DIV_W]  : b_div;
        e_en_n   = ext_wr  ? wr_data[E_EN]            : e_en;
        e_pd_n   = ext_wr  ? wr_data[E_PD]            : e_pd;
        e_byp_n  = ext_wr  ? wr_data[E_BYP]           : e_byp;
        e_div_n  = ext_wr  ? wr_data[E_DIV +: EXT_DIV_W] : e_div;
    end

    // Settings register state; the PLL powers up off and bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xtal_cur <= XTAL_RST;
            b_pd     <= 1'b1;
            b_byp    <= 1'b1;
            b_div    <= '0;
            e_en     <= 1'b0;
            e_pd     <= 1'b0;
            e_byp    <= 1'b0;
            e_div    <= '0;
        end else begin
            xtal_cur <= xtal_nxt;
            b_pd     <= b_pd_n;
            b_byp    <= b_byp_n;
            b_div    <= b_div_n;
            e_en     <= e_en_n;
            e_pd     <= e_pd_n;
            e_byp    <= e_byp_n;
            e_div    <= e_div_n;
        end
    end

    // Effective fields: extension wins while its enable bit is set.
    always_comb begin
        pd_eff   = e_en   ? e_pd   : b_pd;
        byp_eff  = e_en   ? e_byp  : b_byp;
        div_eff  = e_en   ? e_div  : EXT_DIV_W'(b_div);
        pd_eff_n = e_en_n ? e_pd_n : b_pd_n;
    end

    // Relock triggers: a real crystal change, or power-down going 1 to 0.
    assign xtal_chg = (xtal_nxt != xtal_cur);
    assign pd_exit  = pd_eff && !pd_eff_n;

endmodule

// File: rtl/clkctl_relock_timer.sv
// Module: relock down counter on the main-oscillator clock.
// A load reloads the full count even in the middle of a wait.
// Assumes RELOCK_CNT >= 1.
module clkctl_relock_timer #(
    parameter int RELOCK_CNT = 64,
    localparam int CNT_W     = $clog2(RELOCK_CNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic cnt_zero
);

    logic [CNT_W-1:0] cnt;

    // Reload on a trigger, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(RELOCK_CNT);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign cnt_zero = (cnt == '0);

endmodule

// File: rtl/clkctl_xlate.sv
// Module: read-only translated PLL configuration register.
// It is reloaded only when the crystal code really changes.
module clkctl_xlate
    import clkctl_pkg::*;
#(
    parameter logic [XTAL_W-1:0] XTAL_RST = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [XTAL_W-1:0] xtal_nxt,
    output logic [CFG_W-1:0]  cfg
);

    // Hold the table entry for the current crystal code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= xlate_cfg(XTAL_RST);
        else if (upd)
            cfg <= xlate_cfg(xtal_nxt);
    end

endmodule

// File: rtl/clkctl_relock_top.sv
// Module: run-mode clock control with PLL relock gating.
// Assumes that clk is the main oscillator and that writes arrive on it.
module clkctl_relock_top
    import clkctl_pkg::*;
#(
    parameter int                DIV_W      = 4,
    parameter int                EXT_DIV_W  = 7,
    parameter int                RELOCK_CNT = 64,
    parameter logic [XTAL_W-1:0] XTAL_RST   = 4'd2,
    localparam int BASE_W = XTAL_W + 2 + DIV_W,
    localparam int EXT_W  = EXT_DIV_W + 3,
    localparam int WR_W   = (BASE_W > EXT_W) ? BASE_W : EXT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_ext,
    input  logic [WR_W-1:0]      wr_data,
    output logic                 pll_pd,
    output logic                 pll_bypass,
    output logic [EXT_DIV_W-1:0] sys_div,
    output logic [CFG_W-1:0]     pll_cfg,
    output logic                 lock_ready,
    output logic                 use_pll
);

    logic [XTAL_W-1:0] xtal_cur, xtal_nxt;
    logic              xtal_chg, pd_exit, cnt_zero;

    clkctl_regs #(
        .DIV_W(DIV_W), .EXT_DIV_W(EXT_DIV_W), .WR_W(WR_W), .XTAL_RST(XTAL_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ext(wr_ext), .wr_data(wr_data),
        .xtal_cur(xtal_cur), .xtal_nxt(xtal_nxt), .pd_eff(pll_pd),
        .byp_eff(pll_bypass), .div_eff(sys_div), .xtal_chg(xtal_chg), .pd_exit(pd_exit)
    );

    clkctl_relock_timer #(.RELOCK_CNT(RELOCK_CNT)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(xtal_chg || pd_exit), .cnt_zero(cnt_zero)
    );

    clkctl_xlate #(.XTAL_RST(XTAL_RST)) u_xlate (
        .clk(clk), .rst_n(rst_n), .upd(xtal_chg), .xtal_nxt(xtal_nxt), .cfg(pll_cfg)
    );

    // Ready only in normal mode with the wait finished; select follows ready.
    assign lock_ready = !pll_pd && cnt_zero;
    assign use_pll    = lock_ready && !pll_bypass;

endmodule

// File: rtl/clkctl_relock_chk.sv
// Checker: temporal properties of the relock controller, bound to the top.
module clkctl_relock_chk
    import clkctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pll_pd,
    input logic              pll_bypass,
    input logic              lock_ready,
    input logic              use_pll,
    input logic [XTAL_W-1:0] xtal,
    input logic [CFG_W-1:0]  pll_cfg
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pll_pd && pll_bypass && !lock_ready && !use_pll));

    assert_xtal_change_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal != $past(xtal)) |-> !lock_ready);

    assert_ready_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_ready) && !pll_pd && xtal == $past(xtal)) |-> lock_ready);

    assert_pd_exit_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_pd) |-> !lock_ready);

    assert_ready_needs_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_pd) |-> !lock_ready);

    assert_pll_path_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        use_pll |-> (!pll_pd && !pll_bypass));

    assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal == $past(xtal)) |-> $stable(pll_cfg));

endmodule

bind clkctl_relock_top clkctl_relock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pll_pd(pll_pd), .pll_bypass(pll_bypass),
    .lock_ready(lock_ready), .use_pll(use_pll), .xtal(xtal_cur), .pll_cfg(pll_cfg)
);

// File: tb/tb_clkctl_relock_top.sv
`timescale 1ns/1ps
module tb_clkctl_relock_top;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_ext = 1'b0;
    logic [9:0]  wr_data = '0;
    logic        pll_pd, pll_bypass, lock_ready, use_pll;
    logic [6:0]  sys_div;
    logic [11:0] pll_cfg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    clkctl_relock_top #(.RELOCK_CNT(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ext(wr_ext), .wr_data(wr_data),
        .pll_pd(pll_pd), .pll_bypass(pll_bypass), .sys_div(sys_div),
        .pll_cfg(pll_cfg), .lock_ready(lock_ready), .use_pll(use_pll)
    );

    function automatic int exp_cfg(input int code);
        case (code)
            0: return 'h0A3;  1: return 'h112;  2: return 'h1C4;  3: return 'h245;
            4: return 'h2D6;  5: return 'h367;  6: return 'h3F8;  7: return 'h489;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic wr_base(input int xt, input bit pd, input bit byp, input int dv);
        @(negedge clk);
        wr_en = 1'b1; wr_ext = 1'b0;
        wr_data = {dv[3:0], byp, pd, xt[3:0]};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ext_reg(input bit en, input bit pd, input bit byp, input int dv);
        @(negedge clk);
        wr_en = 1'b1; wr_ext = 1'b1;
        wr_data = {en, dv[6:0], byp, pd};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!lock_ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R1", "pll_pd", pll_pd, 1);
        check("R1", "pll_bypass", pll_bypass, 1);
        check("R1", "lock_ready", lock_ready, 0);
        check("R1", "use_pll", use_pll, 0);
        check("R1", "sys_div", sys_div, 0);
        check("R1", "pll_cfg", pll_cfg, exp_cfg(2));
    endtask

    task automatic t_pd_exit;
        int n;
        wr_base(2, 0, 0, 5);
        check("R5", "use_pll during wait", use_pll, 0);
        measure(n);
        check("R5", "relock cycles after power-up", n, N);
        check("R8", "use_pll after lock", use_pll, 1);
        check("R2", "sys_div from base", sys_div, 5);
    endtask

    task automatic t_same_xtal;
        wr_base(2, 0, 0, 5);
        check("R4", "lock_ready after same-code write", lock_ready, 1);
        check("R4", "use_pll after same-code write", use_pll, 1);
        check("R9", "pll_cfg unchanged", pll_cfg, exp_cfg(2));
    endtask

    task automatic t_xtal_change;
        int n;
        wr_base(3, 0, 0, 5);
        check("R8", "use_pll falls back during wait", use_pll, 0);
        check("R9", "pll_cfg code 3", pll_cfg, exp_cfg(3));
        measure(n);
        check("R3", "relock cycles after crystal change", n, N);
    endtask

    task automatic t_retrigger;
        int n;
        wr_base(5, 0, 0, 5);
        repeat (9) @(negedge clk);
        check("R6", "still waiting mid-count", lock_ready, 0);
        wr_base(6, 0, 0, 5);
        measure(n);
        check("R6", "relock cycles after retrigger", n, N);
        check("R9", "pll_cfg code 6", pll_cfg, exp_cfg(6));
    endtask

    task automatic t_unsupported;
        int n;
        wr_base(12, 0, 0, 5);
        check("R9", "pll_cfg default entry", pll_cfg, 0);
        measure(n);
        check("R3", "relock cycles for code 12", n, N);
    endtask

    task automatic t_bypass;
        wr_base(12, 0, 1, 5);
        check("R8", "lock_ready with bypass", lock_ready, 1);
        check("R8", "use_pll with bypass", use_pll, 0);
    endtask

    task automatic t_ext;
        int n;
        wr_ext_reg(1, 0, 0, 'h2B);
        check("R2", "sys_div from extension", sys_div, 'h2B);
        check("R2", "bypass from extension", pll_bypass, 0);
        check("R8", "use_pll with extension", use_pll, 1);
        wr_ext_reg(1, 1, 0, 'h2B);
        check("R2", "power-down from extension", pll_pd, 1);
        check("R7", "lock_ready after extension power-down", lock_ready, 0);
        wr_ext_reg(0, 1, 0, 'h2B);
        check("R2", "sys_div back to base", sys_div, 5);
        check("R2", "bypass back to base", pll_bypass, 1);
        measure(n);
        check("R5", "relock cycles after enable clear", n, N);
    endtask

    task automatic t_power_down;
        wr_base(12, 1, 0, 5);
        check("R7", "lock_ready after power-down", lock_ready, 0);
        check("R8", "use_pll after power-down", use_pll, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pd_exit();
        t_same_xtal();
        t_xtal_change();
        t_retrigger();
        t_unsupported();
        t_bypass();
        t_ext();
        t_power_down();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule